// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast, VCO-rate digital clock down to a comparison clock for a frequency synthesizer loop. The total ratio is P·N + A. A synchronous dual-modulus prescaler counts either P or P+1 input clocks per prescaler cycle. A swallow counter holds the prescaler in its P+1 modulus for the first A prescaler cycles of every division cycle. A main counter closes the division cycle after N prescaler cycles. Each time a division cycle completes, the block emits one pulse on `fpOut`.

A one-clock `loadStb` takes a new main count, swallow count and modulus pair into a shadow register. The running counters pick up the shadow contents only at the next division boundary, so no period is ever cut short or stretched by a write. A setting that cannot be divided as requested raises `cfgErr`, and the block runs a clamped version of that setting.

The two modulus pairs are parameters. The defaults, 8/9 and 16/17, suit the low-frequency channel. Setting them to 64 and 128 gives the 64/65 and 128/129 pairs of the high-frequency channel.

Top module: `pulseSwallowDivider`

## Requirements
- R1: The spacing between consecutive `fpOut` pulses is P·N + A input clocks. With the default parameters, `modSel`=0 selects P=8 (8/9 pair) and `modSel`=1 selects P=16 (16/17 pair).
- R2: When A=0, every prescaler cycle uses modulus P, so the period is exactly P·N.
- R3: `fpOut` is high for exactly one input clock per division cycle.
- R4: A `loadStb` in the middle of a division cycle leaves that cycle's length unchanged. The new setting governs the next full cycle.
- R5: Changes on `nValue`, `aValue` and `modSel` while `loadStb` is low have no effect on the output period.
- R6: `cfgErr` is updated on every `loadStb`. It goes high when N<3 or A≥N is loaded, and it goes low again when a legal setting is loaded.
- R7: An illegal setting runs with N raised to 3 when it is below 3, and with A reduced to N−1 when A is not below the effective N.
- R8: During reset `fpOut` and `cfgErr` are low. After reset the block divides by 3·P with P from `modSel`=0 (24 by default) until the first load takes effect.
- R9: The extreme legal values N=2047 and A=127 give the full ratio P·2047+127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (divided signal) |
| rstN | input | 1 | Asynchronous active-low reset |
| nValue | input | 11 | Main counter setting N |
| aValue | input | 7 | Swallow counter setting A |
| modSel | input | 1 | Prescaler pair select: 0 lower pair, 1 upper pair |
| loadStb | input | 1 | One-clock strobe that captures the settings |
| fpOut | output | 1 | One-clock pulse per completed division cycle |
| cfgErr | output | 1 | High while the last loaded setting is illegal |

## Verification
The bench measures the spacing between pulses for both modulus pairs. It covers A=0, A close to N and the largest N and A. A design that miscounted the swallow phase would be off by a multiple of A or would lose the +A term.

The bench also loads a new setting just after a boundary and checks that the period in progress keeps its old length. A design that let the counters load immediately would produce a runt period.

Illegal loads are applied with N below 3 and with A equal to or above N. A wrong clamp shows up as a period that differs from the clamped value, or as an error flag that does not follow the load.

Finally, the bench moves the setting inputs without a strobe and expects the period to stay unchanged.

// File: rtl/pswPkg.sv
package pswPkg;
  typedef struct packed {
    logic capture;
    logic advance;
    logic reload;
  } pswStrobe_t;

  typedef struct packed {
    logic lastMain;
    logic swallowLeft;
    logic hiMod;
  } pswStatus_t;
endpackage

// File: rtl/pswDatapath.sv
module pswDatapath
  import pswPkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int N_MIN = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NW-1:0] nValue,
  input  logic [AW-1:0] aValue,
  input  logic          modSel,
  input  pswStrobe_t    strobe,
  output pswStatus_t    status,
  output logic          cfgErr
);
  localparam logic [NW-1:0] nFloor = NW'(N_MIN);
  localparam int XW = NW - AW;

  logic [NW-1:0] shadowN, nCnt, effN;
  logic [AW-1:0] shadowA, aCnt, effA;
  logic          shadowSel, activeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowN   <= nFloor;
      shadowA   <= '0;
      shadowSel <= 1'b0;
      cfgErr    <= 1'b0;
    end else if (strobe.capture) begin
      shadowN   <= nValue;
      shadowA   <= aValue;
      shadowSel <= modSel;
      cfgErr    <= (nValue < nFloor) || ({{XW{1'b0}}, aValue} >= nValue);
    end
  end

  always_comb begin
    effN = (shadowN < nFloor) ? nFloor : shadowN;
    if ({{XW{1'b0}}, shadowA} >= effN) effA = AW'(effN - NW'(1));
    else                               effA = shadowA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCnt      <= nFloor;
      aCnt      <= '0;
      activeSel <= 1'b0;
    end else if (strobe.reload) begin
      nCnt      <= effN;
      aCnt      <= effA;
      activeSel <= shadowSel;
    end else if (strobe.advance) begin
      nCnt <= nCnt - NW'(1);
      if (aCnt != '0) aCnt <= aCnt - AW'(1);
    end
  end

  assign status.lastMain    = (nCnt == NW'(1));
  assign status.swallowLeft = (aCnt != '0);
  assign status.hiMod       = activeSel;

  assert_swallow_below_main_R7: assert property (@(posedge clk) disable iff (!rstN)
    ({{XW{1'b0}}, aCnt} < nCnt)) else $error("swallow count reached main count");

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(shadowN) && $stable(shadowA) && $stable(shadowSel))
    else $error("shadow changed without strobe");

  assert_active_at_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reload |=> $stable(activeSel)) else $error("modulus changed mid cycle");

  assert_err_follows_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> cfgErr == (($past(nValue) < nFloor) ||
                                  ({{XW{1'b0}}, $past(aValue)} >= $past(nValue))))
    else $error("error flag mismatch");
endmodule

// File: rtl/pswControl.sv
module pswControl
  import pswPkg::*;
#(
  parameter int P_LO = 8,
  parameter int P_HI = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  pswStatus_t status,
  output pswStrobe_t strobe,
  output logic       fpOut
);
  localparam int PW = $clog2(P_HI + 1);
  localparam logic [PW-1:0] baseLo = PW'(P_LO - 1);
  localparam logic [PW-1:0] baseHi = PW'(P_HI - 1);

  logic [PW-1:0] preCnt, preTop;
  logic          preWrap;

  always_comb begin
    preTop  = (status.hiMod ? baseHi : baseLo) + PW'(status.swallowLeft);
    preWrap = (preCnt == preTop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (preWrap) preCnt <= '0;
    else              preCnt <= preCnt + PW'(1);
  end

  assign strobe.capture = loadStb;
  assign strobe.advance = preWrap & ~status.lastMain;
  assign strobe.reload  = preWrap & status.lastMain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fpOut <= 1'b0;
    else       fpOut <= strobe.reload;
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    fpOut |=> !fpOut) else $error("pulse wider than one clock");

  assert_prescaler_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PW'(P_HI)) else $error("prescaler count out of range");
endmodule

// File: rtl/pulseSwallowDivider.sv
module pulseSwallowDivider
  import pswPkg::*;
#(
  parameter int P_LO = 8,
  parameter int P_HI = 16,
  parameter int NW   = 11,
  parameter int AW   = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NW-1:0] nValue,
  input  logic [AW-1:0] aValue,
  input  logic          modSel,
  input  logic          loadStb,
  output logic          fpOut,
  output logic          cfgErr
);
  pswStrobe_t strobe;
  pswStatus_t status;

  pswControl #(.P_LO(P_LO), .P_HI(P_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb),
    .status(status), .strobe(strobe), .fpOut(fpOut)
  );

  pswDatapath #(.NW(NW), .AW(AW), .N_MIN(3)) uData (
    .clk(clk), .rstN(rstN), .nValue(nValue), .aValue(aValue),
    .modSel(modSel), .strobe(strobe), .status(status), .cfgErr(cfgErr)
  );
endmodule

// File: tb/sim_pulseSwallowDivider.sv
module sim_pulseSwallowDivider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] nValue = 11'd0;
  logic [6:0]  aValue = 7'd0;
  logic modSel = 1'b0;
  logic loadStb = 1'b0;
  logic fpOut, cfgErr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pulseSwallowDivider u0 (
    .clk(clk), .rstN(rstN), .nValue(nValue), .aValue(aValue),
    .modSel(modSel), .loadStb(loadStb), .fpOut(fpOut), .cfgErr(cfgErr)
  );

  localparam int NV = 10;
  localparam int VN  [NV] = '{10, 3, 5, 100, 1, 10, 4, 200, 2047, 1000};
  localparam int VA  [NV] = '{3, 0, 4, 0, 1, 12, 4, 127, 127, 127};
  localparam int VS  [NV] = '{0, 1, 1, 0, 0, 0, 1, 1, 0, 1};
  localparam int VP  [NV] = '{83, 48, 84, 800, 25, 89, 67, 3327, 16503, 16127};
  localparam int VE  [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 0};
  localparam string VR [NV] = '{"R1", "R2", "R1", "R2", "R7", "R7", "R7", "R1", "R9", "R9"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitFp(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (fpOut) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c1, c2, prev;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 fp in reset", int'(fpOut), 0);
    check("R8 err in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    waitFp(c1);
    waitFp(c2);
    check("R8 default period", c2, 24);
    // R3: one clock wide
    @(negedge clk);
    check("R3 pulse width", int'(fpOut), 0);
    waitFp(c2);
    check("R3 period after width check", c2 + 1, 24);
    // R5: inputs move without strobe
    nValue = 11'd50; aValue = 7'd7; modSel = 1'b1;
    waitFp(c1);
    waitFp(c2);
    check("R5 no strobe period", c2, 24);
    check("R5 no strobe err", int'(cfgErr), 0);
    prev = 24;
    for (int i = 0; i < NV; i++) begin
      waitFp(c1);
      nValue = 11'(VN[i]); aValue = 7'(VA[i]); modSel = 1'(VS[i]);
      loadStb = 1'b1;
      @(negedge clk);
      loadStb = 1'b0;
      waitFp(c1);
      check("R4 cycle in progress kept", c1 + 1, prev);
      waitFp(c2);
      check(VR[i], c2, VP[i]);
      check("R6 error flag", int'(cfgErr), VE[i]);
      prev = VP[i];
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule